// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block is the hardware walker that a TLB calls on a miss. It takes a 32-bit virtual address and reads descriptors through a plain memory read port with a request and a response. It reads one first-level descriptor, and a second-level descriptor when the first one points to a further table. From these it forms the physical address, the mapping size and the attribute bits that the TLB needs for its fill. If a descriptor holds no valid mapping, it reports a translation fault and gives no address.

Two table bases are available. A split count N, sampled when a walk is accepted, selects the base. If all of the top N virtual address bits are zero, the walk uses the low base. Otherwise it uses the high base. Four mapping sizes are decoded: 4 KB, 64 KB, 1 MB and 16 MB. The 16 MB mapping widens the result to 40 bits. The walker takes one walk at a time and holds `busy` from acceptance until it delivers the result.

Top module: `tw_walker`

## Requirements
- R1: A walk is accepted on a clock edge where `req_valid` is high and `busy` is low. `split_n` and `req_va` are sampled on that edge. When any of the top `split_n` bits of the virtual address is 1, the walk uses `tbase1`. Otherwise it uses `tbase0`. A `split_n` of 0 always selects `tbase0`.
- R2: The first-level read address is {base[17:0], VA[31:20], 2'b00}. The base field holds the table address bits 31:14.
- R3: A first-level descriptor with bits [1:0]=10 and bit 18 clear maps a 1 MB block. The result is `pa` = {8'h00, desc[31:20], VA[19:0]} with `page_size`=2.
- R4: A first-level descriptor with bits [1:0]=10 and bit 18 set maps a 16 MB block. The result is `pa` = {desc[23:20], desc[8:5], desc[31:24], VA[23:0]} with `page_size`=3.
- R5: A first-level descriptor with bits [1:0]=01 points to a second-level table. The second-level read address is {desc[31:10], VA[19:12], 2'b00}. A second-level descriptor with bit 1 set maps a 4 KB page. The result is `pa` = {8'h00, desc[31:12], VA[11:0]} with `page_size`=0.
- R6: A second-level descriptor with bits [1:0]=01 maps a 64 KB page. The result is `pa` = {8'h00, desc[31:16], VA[15:0]} with `page_size`=1. The table holds this entry replicated across the 16 slots that VA[15:12] can select.
- R7: A first-level descriptor with bits [1:0] equal to 00 or 11 ends the walk with `fault` and makes no second-level read.
- R8: A second-level descriptor with bits [1:0]=00 ends the walk with `fault`.
- R9: While `busy` is high, `req_valid` is ignored. The walk in progress completes with its own result, and no extra memory read is issued. `busy` falls in the cycle after the result pulse.
- R10: A walk ends with a one-cycle pulse on exactly one of `done` and `fault`. Each table level issues exactly one single-cycle `mem_req`, and `mem_addr` stays stable until the response arrives. A response may arrive any number of cycles later.
- R11: After reset `busy`, `mem_req`, `done` and `fault` are low. A reset during a walk abandons the walk.
- R12: On `done`, `attr` holds bits [11:2] of the descriptor that produced the mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a walk (taken when idle) |
| req_va | input | 32 | Virtual address to translate |
| split_n | input | 3 | Count of top VA bits tested for base choice |
| tbase0 | input | 18 | Low table base, address bits 31:14 |
| tbase1 | input | 18 | High table base, address bits 31:14 |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Descriptor read request, one cycle |
| mem_addr | output | 32 | Descriptor read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor read data |
| done | output | 1 | Translation result valid, one cycle |
| fault | output | 1 | Translation fault, one cycle |
| pa | output | 40 | Physical address |
| page_size | output | 2 | 0=4 KB, 1=64 KB, 2=1 MB, 3=16 MB |
| attr | output | 10 | Attribute bits of the final descriptor |

## Verification
The bench targets the base split at its edges. With N=7 it tries one address just below bit 25 and one at bit 25; a design that tests the wrong bit range reads from the wrong table. It drives the 16 MB case with distinct extended-base nibbles, which catches swapped or dropped upper address bits. It also drives the reserved first-level code 11, which a careless decoder would treat as a block. It keeps requesting during a walk, which exposes a walker that restarts or issues a second read. It uses response latencies from zero to three extra cycles and resets the walker in the middle of a walk, which catches a walker that samples data too early or keeps stale state.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 40;
    localparam int ATTR_W = 10;
    localparam int BASE_W = 18;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE, ST_FAULT
    } walk_st_e;

    typedef enum logic [1:0] {
        SZ_4K = 2'd0, SZ_64K = 2'd1, SZ_1M = 2'd2, SZ_16M = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        DK_FAULT, DK_TABLE, DK_LEAF
    } desc_kind_e;

    typedef struct packed {
        walk_st_e          st;
        logic [23:0]       va;
        logic [VA_W-1:0]   addr;
        logic [PA_W-1:0]   pa;
        pg_size_e          size;
        logic [ATTR_W-1:0] attr;
    } walk_regs_t;
endpackage

// File: rtl/tw_base_sel.sv
module tw_base_sel #(
    parameter int SPLIT_W = 3,
    parameter int BASE_W  = 18
) (
    input  logic [11:0]       va_top,
    input  logic [SPLIT_W-1:0] split_n,
    input  logic [BASE_W-1:0] tbase0,
    input  logic [BASE_W-1:0] tbase1,
    output logic [31:0]       l1_addr
);
    localparam int TEST_W = (1 << SPLIT_W) - 1;

    logic use_hi;

    always_comb begin
        use_hi = 1'b0;
        for (int i = 0; i < TEST_W; i++) begin
            if ((i < int'(split_n)) && va_top[11-i]) use_hi = 1'b1;
        end
        l1_addr = {(use_hi ? tbase1 : tbase0), va_top, 2'b00};
    end
endmodule

// File: rtl/tw_desc_decode.sv
module tw_desc_decode
    import tw_pkg::*;
(
    input  logic              level2,
    input  logic [31:0]       desc,
    input  logic [23:0]       va_lo,
    output desc_kind_e        kind,
    output logic [PA_W-1:0]   leaf_pa,
    output pg_size_e          leaf_size,
    output logic [ATTR_W-1:0] leaf_attr
);
    always_comb begin
        kind      = DK_FAULT;
        leaf_pa   = '0;
        leaf_size = SZ_4K;
        leaf_attr = desc[11:2];
        if (!level2) begin
            unique case (desc[1:0])
                2'b01: kind = DK_TABLE;
                2'b10: begin
                    kind = DK_LEAF;
                    if (desc[18]) begin
                        leaf_pa   = {desc[23:20], desc[8:5], desc[31:24], va_lo[23:0]};
                        leaf_size = SZ_16M;
                    end else begin
                        leaf_pa   = {8'h00, desc[31:20], va_lo[19:0]};
                        leaf_size = SZ_1M;
                    end
                end
                default: kind = DK_FAULT;
            endcase
        end else begin
            if (desc[1]) begin
                kind      = DK_LEAF;
                leaf_pa   = {8'h00, desc[31:12], va_lo[11:0]};
                leaf_size = SZ_4K;
            end else if (desc[0]) begin
                kind      = DK_LEAF;
                leaf_pa   = {8'h00, desc[31:16], va_lo[15:0]};
                leaf_size = SZ_64K;
            end
        end
    end
endmodule

// File: rtl/tw_walker.sv
module tw_walker
    import tw_pkg::*;
#(
    parameter int SPLIT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [31:0]        req_va,
    input  logic [SPLIT_W-1:0] split_n,
    input  logic [17:0]        tbase0,
    input  logic [17:0]        tbase1,
    output logic               busy,
    output logic               mem_req,
    output logic [31:0]        mem_addr,
    input  logic               mem_rvalid,
    input  logic [31:0]        mem_rdata,
    output logic               done,
    output logic               fault,
    output logic [39:0]        pa,
    output logic [1:0]         page_size,
    output logic [9:0]         attr
);
    walk_regs_t  r_q, r_d;
    logic [31:0] l1_addr;
    desc_kind_e  kind;
    logic [PA_W-1:0]   leaf_pa;
    pg_size_e          leaf_size;
    logic [ATTR_W-1:0] leaf_attr;

    tw_base_sel #(.SPLIT_W(SPLIT_W), .BASE_W(BASE_W)) u_base (
        .va_top (req_va[31:20]),
        .split_n(split_n),
        .tbase0 (tbase0),
        .tbase1 (tbase1),
        .l1_addr(l1_addr)
    );

    tw_desc_decode u_dec (
        .level2   (r_q.st == ST_L2_WAIT),
        .desc     (mem_rdata),
        .va_lo    (r_q.va),
        .kind     (kind),
        .leaf_pa  (leaf_pa),
        .leaf_size(leaf_size),
        .leaf_attr(leaf_attr)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: if (req_valid) begin
                r_d.va   = req_va[23:0];
                r_d.addr = l1_addr;
                r_d.st   = ST_L1_REQ;
            end
            ST_L1_REQ: r_d.st = ST_L1_WAIT;
            ST_L2_REQ: r_d.st = ST_L2_WAIT;
            ST_L1_WAIT, ST_L2_WAIT: if (mem_rvalid) begin
                unique case (kind)
                    DK_TABLE: begin
                        r_d.addr = {mem_rdata[31:10], r_q.va[19:12], 2'b00};
                        r_d.st   = ST_L2_REQ;
                    end
                    DK_LEAF: begin
                        r_d.pa   = leaf_pa;
                        r_d.size = leaf_size;
                        r_d.attr = leaf_attr;
                        r_d.st   = ST_DONE;
                    end
                    default: r_d.st = ST_FAULT;
                endcase
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, va: '0, addr: '0, pa: '0, size: SZ_4K, attr: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign mem_req   = (r_q.st == ST_L1_REQ) || (r_q.st == ST_L2_REQ);
    assign mem_addr  = r_q.addr;
    assign done      = (r_q.st == ST_DONE);
    assign fault     = (r_q.st == ST_FAULT);
    assign pa        = r_q.pa;
    assign page_size = r_q.size;
    assign attr      = r_q.attr;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) !(done && fault)); // R10
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> !mem_req); // R10
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) mem_req |=> $stable(mem_addr)); // R10
    AST_REQ_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy); // R9
    AST_RESULT_FREES: assert property (@(posedge clk) disable iff (!rst_n) (done || fault) |=> !busy); // R9
    AST_PA_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (done && page_size != 2'd3) |-> (pa[39:32] == 8'h00)); // R3
endmodule

// File: tb/tw_walker_test.sv
module tw_walker_test;
    typedef struct packed {
        logic [31:0] va;
        logic [2:0]  split;
        logic [31:0] l1;
        logic [31:0] l2;
        logic [1:0]  lat;
        logic        extra;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{32'h1234_5678, 3'd0, 32'hABC0_0C0E, 32'h0,           2'd0, 1'b0}, // R3 section
        '{32'h9234_5678, 3'd2, 32'h5F94_01A2, 32'h0,           2'd1, 1'b0}, // R4 R1 high base
        '{32'h7654_3210, 3'd1, 32'h0012_3401, 32'hCAFE_B03E,   2'd2, 1'b0}, // R5 small
        '{32'h2000_ABCD, 3'd3, 32'h0456_7801, 32'h1357_0005,   2'd0, 1'b0}, // R6 large
        '{32'h4444_0000, 3'd0, 32'h0000_0000, 32'h0,           2'd1, 1'b0}, // R7 fault 00
        '{32'h4444_0000, 3'd0, 32'hFFFF_FFFF, 32'h0,           2'd0, 1'b0}, // R7 fault 11
        '{32'h0ABC_D000, 3'd4, 32'h0088_1C01, 32'h1234_5600,   2'd3, 1'b0}, // R8 L2 fault
        '{32'h01FF_FFFF, 3'd7, 32'h7770_0002, 32'h0,           2'd3, 1'b0}, // R1 edge low
        '{32'h0200_0000, 3'd7, 32'h8880_0A4A, 32'h0,           2'd1, 1'b1}, // R1 edge high, R9
        '{32'hF00F_1234, 3'd5, 32'h0123_4401, 32'h00AB_C0F2,   2'd2, 1'b1}  // R9 R12 small
    };

    localparam logic [17:0] TB0 = 18'h00001;
    localparam logic [17:0] TB1 = 18'h20003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic [2:0]  split_n = '0;
    logic        busy, mem_req, done, fault;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [39:0] pa;
    logic [1:0]  page_size;
    logic [9:0]  attr;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tw_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .split_n(split_n), .tbase0(TB0), .tbase1(TB1), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .fault(fault), .pa(pa),
        .page_size(page_size), .attr(attr)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model(input vec_t v, output logic [31:0] l1a, output logic [31:0] l2a,
                         output int nreq, output bit flt, output logic [39:0] epa,
                         output logic [1:0] esz, output logic [9:0] eat);
        bit hi = 1'b0;
        for (int i = 0; i < int'(v.split); i++) if (v.va[31-i]) hi = 1'b1;
        l1a = {(hi ? TB1 : TB0), v.va[31:20], 2'b00};
        l2a = '0; nreq = 1; flt = 1'b0; epa = '0; esz = '0; eat = '0;
        case (v.l1[1:0])
            2'b10: begin
                eat = v.l1[11:2];
                if (v.l1[18]) begin
                    epa = {v.l1[23:20], v.l1[8:5], v.l1[31:24], v.va[23:0]}; esz = 2'd3;
                end else begin
                    epa = {8'h00, v.l1[31:20], v.va[19:0]}; esz = 2'd2;
                end
            end
            2'b01: begin
                nreq = 2;
                l2a = {v.l1[31:10], v.va[19:12], 2'b00};
                eat = v.l2[11:2];
                if (v.l2[1]) begin
                    epa = {8'h00, v.l2[31:12], v.va[11:0]}; esz = 2'd0;
                end else if (v.l2[0]) begin
                    epa = {8'h00, v.l2[31:16], v.va[15:0]}; esz = 2'd1;
                end else flt = 1'b1;
            end
            default: flt = 1'b1;
        endcase
    endtask

    task automatic run_walk(input vec_t v, input string tag);
        logic [31:0] l1a, l2a, got_a;
        int nreq, seen = 0, cnt = 0;
        bit flt, pend = 1'b0, fin = 1'b0, got_done = 1'b0, got_fault = 1'b0;
        logic [39:0] epa;
        logic [1:0]  esz;
        logic [9:0]  eat;
        model(v, l1a, l2a, nreq, flt, epa, esz, eat);
        @(negedge clk);
        req_valid = 1'b1; req_va = v.va; split_n = v.split;
        for (int c = 0; c < 40 && !fin; c++) begin
            @(negedge clk);
            if (v.extra) begin req_va = ~v.va; split_n = 3'd0; end
            else req_valid = 1'b0;
            mem_rvalid = 1'b0;
            if (done || fault) begin
                fin = 1'b1; got_done = done; got_fault = fault;
            end
            if (c == 1) chk(busy == 1'b1, {tag, " R9 busy mid-walk"}, busy, 1);
            if (pend) begin
                if (cnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata = (seen == 1) ? v.l1 : v.l2;
                    pend = 1'b0;
                end else cnt--;
            end
            if (mem_req) begin
                seen++;
                got_a = mem_addr;
                if (seen == 1) chk(got_a == l1a, {tag, " R2 L1 address"}, got_a, l1a);
                else if (seen == 2) chk(got_a == l2a, {tag, " R5 L2 address"}, got_a, l2a);
                pend = 1'b1; cnt = int'(v.lat);
            end
        end
        req_valid = 1'b0;
        mem_rvalid = 1'b0;
        chk(fin, {tag, " R10 walk finished"}, fin, 1);
        chk(seen == nreq, {tag, " R10 R9 read count"}, seen, nreq);
        chk(got_fault == flt && got_done == !flt, {tag, " R7 R8 outcome"}, {got_done, got_fault}, {!flt, flt});
        if (!flt) begin
            chk(pa == epa, {tag, " R3 R4 R5 R6 pa"}, pa, epa);
            chk(page_size == esz, {tag, " R3 R4 R5 R6 size"}, page_size, esz);
            chk(attr == eat, {tag, " R12 attr"}, attr, eat);
        end
        @(negedge clk);
        chk(busy == 1'b0, {tag, " R9 busy released"}, busy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({busy, mem_req, done, fault} == 4'b0, "R11 reset state", {busy, mem_req, done, fault}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, mem_req, done, fault} == 4'b0, "R11 idle after reset", {busy, mem_req, done, fault}, 0);

        for (int i = 0; i < NV; i++) run_walk(VECS[i], $sformatf("vec%0d", i));

        // R11: reset in the middle of a walk abandons it
        @(negedge clk);
        req_valid = 1'b1; req_va = 32'h1111_1111; split_n = 3'd0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R11 walk started", busy, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk({busy, mem_req, done, fault} == 4'b0, "R11 reset aborts walk", {busy, mem_req, done, fault}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({busy, mem_req, done, fault} == 4'b0, "R11 stays idle", {busy, mem_req, done, fault}, 0);

        // R1 with N=0: top bit set still selects low base
        run_walk('{32'hFFF0_0123, 3'd0, 32'h3210_0402, 32'h0, 2'd0, 1'b0}, "n0");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule